// File: doc/BRIEF.md
# Masked Scalar FP32 Add Unit

This block adds the lowest 32-bit single-precision lane of two operands and builds a full 512-bit destination vector around that sum. One of three merge behaviours is picked per operation. The legacy form adds into the old destination and leaves the rest of it untouched. The three-operand form takes the upper part of a 128-bit first source and clears everything above 128 bits. The masked form does the same as the three-operand form, but one mask bit decides whether lane 0 receives the sum, keeps its old value or is cleared.

The rounding direction comes from a per-operation override when that override is enabled and the second operand is a register. Otherwise it comes from a global rounding field. The adder handles subnormal inputs with gradual underflow and reports five IEEE exception flags. The datapath is combinational, and a parameter places a register on the result and the flags.

Top module: `scalar_fadd`

## Requirements
- R1: `mode_i` is encoded as 00 legacy, 01 three-operand, 10 masked and 11 three-operand. In masked mode with `mask_en_i`=0 or `mask_bit_i`=1, and in both three-operand codes whatever the mask inputs are, `res_o[31:0]` is the FP32 sum of `src1_i[31:0]` and `src2_i`.
- R2: In masked mode with `mask_en_i`=1, `mask_bit_i`=0 and `zero_mask_i`=0, `res_o[31:0]` equals `dst_i[31:0]`.
- R3: In masked mode with `mask_en_i`=1, `mask_bit_i`=0 and `zero_mask_i`=1, `res_o[31:0]` is zero.
- R4: In every mode other than legacy, `res_o[127:32]` equals `src1_i[127:32]` and `res_o[511:128]` is zero.
- R5: In legacy mode, `res_o[31:0]` is the FP32 sum of `dst_i[31:0]` and `src2_i`, `res_o[511:32]` equals `dst_i[511:32]`, and `src1_i` has no effect.
- R6: The rounding field is encoded as 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. `er_rc_i` is used when both `er_en_i` and `src2_reg_i` are 1. Otherwise `glob_rc_i` is used.
- R7: The sum is rounded correctly in all four directions, with ties going to the even value. `flags_o[4]` (inexact) is set whenever the rounded sum differs from the exact sum. `flags_o` is ordered {inexact, underflow, overflow, denormal, invalid} from bit 4 down to bit 0.
- R8: On overflow, `flags_o[2]` and `flags_o[4]` are set. The result is infinity when rounding to nearest or away from zero toward the result's sign, and the largest finite value of that sign otherwise.
- R9: Opposite-signed infinities, or any signalling-NaN input, set `flags_o[0]` and give 0x7FC00000. A quiet-NaN input is returned with its quiet bit set and raises no flag.
- R10: `flags_o[1]` is set when either input has a zero exponent and a nonzero fraction. Such inputs are added as subnormals. `flags_o[3]` is set only for a tiny result that is also inexact.
- R11: An exact zero sum of opposite-signed operands is -0 under rounding toward minus infinity and +0 in the other directions.
- R12: When lane 0 is masked off (R2 or R3), `flags_o` is zero.
- R13: With `REG_OUT`=1, `res_o` and `flags_o` reflect the inputs present at the preceding rising clock edge, and an active-low `rst_ni` clears both asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Merge behaviour select |
| src1_i | input | 128 | First source vector |
| src2_i | input | 32 | Low lane of the second source |
| dst_i | input | 512 | Old destination vector |
| mask_en_i | input | 1 | A mask is in use (masked mode only) |
| mask_bit_i | input | 1 | Mask bit for lane 0 |
| zero_mask_i | input | 1 | 1 clears a masked-off lane, 0 keeps it |
| er_en_i | input | 1 | Per-operation rounding override enable |
| er_rc_i | input | 2 | Per-operation rounding field |
| src2_reg_i | input | 1 | Second source is a register |
| glob_rc_i | input | 2 | Global rounding field |
| res_o | output | 512 | Destination vector |
| flags_o | output | 5 | {inexact, underflow, overflow, denormal, invalid} |

## Verification
The hardest cases to reach are the rounding boundaries. For these the alignment shift leaves exactly a half unit in the last place, or only a sticky bit, and the result depends on the selected direction and on the parity of the kept significand. The stimulus builds these cases from chosen operand pairs: one added a power of two exactly 24 binades below the other, a tie on an odd significand, and a far-smaller operand that only sets sticky. Each pair is run under every rounding direction and under every combination of override enable and register flag. The masked-off paths are driven with a signalling NaN in the lane, so any flag that leaks out is seen at the port.

// File: rtl/scalar_fadd_pkg.sv
package scalar_fadd_pkg;

  localparam int FP_W = 32;

  typedef enum logic [1:0] {
    MD_LEGACY = 2'b00,
    MD_TRIO   = 2'b01,
    MD_MASKED = 2'b10,
    MD_TRIO_B = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    RM_RNE = 2'b00,
    RM_RDN = 2'b01,
    RM_RUP = 2'b10,
    RM_RTZ = 2'b11
  } rmode_e;

  typedef struct packed {
    logic inexact;
    logic underflow;
    logic overflow;
    logic denormal;
    logic invalid;
  } fflags_t;

  localparam logic [FP_W-1:0] QNAN_DFLT = 32'h7FC0_0000;

  function automatic logic [4:0] lzc27(input logic [26:0] v);
    logic [4:0] n;
    logic       hit;
    n   = 5'd27;
    hit = 1'b0;
    for (int i = 26; i >= 0; i--) begin
      if (!hit && v[i]) begin
        n   = 5'(26 - i);
        hit = 1'b1;
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/fp32_classify.sv
module fp32_classify (
  input  logic [31:0] op_i,
  output logic        sign_o,
  output logic [7:0]  exp_o,
  output logic [23:0] sig_o,
  output logic        nan_o,
  output logic        snan_o,
  output logic        inf_o,
  output logic        dnm_o
);
  logic       exp_max, exp_zero, frac_nz;

  assign exp_max  = &op_i[30:23];
  assign exp_zero = ~|op_i[30:23];
  assign frac_nz  = |op_i[22:0];

  assign sign_o = op_i[31];
  // subnormals share the scale of exponent 1
  assign exp_o  = exp_zero ? 8'd1 : op_i[30:23];
  assign sig_o  = {~exp_zero, op_i[22:0]};
  assign nan_o  = exp_max & frac_nz;
  assign snan_o = exp_max & frac_nz & ~op_i[22];
  assign inf_o  = exp_max & ~frac_nz;
  assign dnm_o  = exp_zero & frac_nz;
endmodule

// File: rtl/fp32_add_core.sv
module fp32_add_core
  import scalar_fadd_pkg::*;
(
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  input  logic [1:0]      rm_i,
  output logic [FP_W-1:0] sum_o,
  output fflags_t         flags_o
);
  localparam int NOP = 2;

  logic [FP_W-1:0] opnd [NOP];
  logic [NOP-1:0]  sgn, nan, snan, inf, dnm;
  logic [7:0]      xe  [NOP];
  logic [23:0]     sg  [NOP];

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar i = 0; i < NOP; i++) begin : g_cls
    fp32_classify u_cls (
      .op_i   (opnd[i]),
      .sign_o (sgn[i]),
      .exp_o  (xe[i]),
      .sig_o  (sg[i]),
      .nan_o  (nan[i]),
      .snan_o (snan[i]),
      .inf_o  (inf[i]),
      .dnm_o  (dnm[i])
    );
  end

  // magnitude order, swap so "big" has the larger magnitude
  logic        a_ge, eff_sub, big_s;
  logic [7:0]  big_x, sml_x, diff;
  logic [23:0] big_m, sml_m;

  assign a_ge    = a_i[30:0] >= b_i[30:0];
  assign eff_sub = sgn[0] ^ sgn[1];
  assign big_s   = a_ge ? sgn[0] : sgn[1];
  assign big_x   = a_ge ? xe[0]  : xe[1];
  assign sml_x   = a_ge ? xe[1]  : xe[0];
  assign big_m   = a_ge ? sg[0]  : sg[1];
  assign sml_m   = a_ge ? sg[1]  : sg[0];
  assign diff    = big_x - sml_x;

  // align with guard, round and sticky bits
  logic [26:0] big_e, sml_e, sml_sh;
  logic        align_lost;

  assign big_e = {big_m, 3'b000};
  assign sml_e = {sml_m, 3'b000};

  always_comb begin
    sml_sh     = '0;
    align_lost = 1'b0;
    if (diff >= 8'd27) begin
      sml_sh[0] = |sml_m;
    end else begin
      sml_sh     = sml_e >> diff[4:0];
      align_lost = |(sml_e & ~({27{1'b1}} << diff[4:0]));
      sml_sh[0]  = sml_sh[0] | align_lost;
    end
  end

  logic [27:0] sum_w;
  assign sum_w = eff_sub ? ({1'b0, big_e} - {1'b0, sml_sh})
                         : ({1'b0, big_e} + {1'b0, sml_sh});

  // normalise; left shift stops at exponent 1 (gradual underflow)
  logic [26:0] nrm;
  logic [9:0]  nexp;
  logic [4:0]  lz;
  logic [7:0]  max_shl, shl;

  assign lz      = lzc27(sum_w[26:0]);
  assign max_shl = big_x - 8'd1;
  assign shl     = ({3'b000, lz} > max_shl) ? max_shl : {3'b000, lz};

  always_comb begin
    if (sum_w[27]) begin
      nrm  = {sum_w[27:2], sum_w[1] | sum_w[0]};
      nexp = {2'b00, big_x} + 10'd1;
    end else begin
      nrm  = sum_w[26:0] << shl;
      nexp = {2'b00, big_x} - {2'b00, shl};
    end
  end

  // rounding
  logic        lsb, grd, stk, inx, rup, tiny, ovf, huge_inf;
  logic [9:0]  exp_f;
  logic [32:0] pk;

  assign lsb   = nrm[3];
  assign grd   = nrm[2];
  assign stk   = |nrm[1:0];
  assign inx   = grd | stk;
  assign tiny  = ~nrm[26];
  assign exp_f = nrm[26] ? nexp : 10'd0;

  always_comb begin
    unique case (rm_i)
      RM_RNE:  rup = grd & (stk | lsb);
      RM_RDN:  rup = big_s & inx;
      RM_RUP:  rup = ~big_s & inx;
      default: rup = 1'b0;
    endcase
  end

  // fraction carry ripples into the exponent field
  assign pk  = {exp_f, nrm[25:3]} + {32'd0, rup};
  assign ovf = pk[32:23] >= 10'd255;

  assign huge_inf = (rm_i == RM_RNE) | ((rm_i == RM_RUP) & ~big_s)
                  | ((rm_i == RM_RDN) & big_s);

  always_comb begin
    flags_o          = '0;
    flags_o.denormal = |dnm;
    if ((|snan) | (inf[0] & inf[1] & eff_sub)) begin
      sum_o           = QNAN_DFLT;
      flags_o.invalid = 1'b1;
    end else if (|nan) begin
      sum_o = nan[0] ? (a_i | 32'h0040_0000) : (b_i | 32'h0040_0000);
    end else if (|inf) begin
      sum_o = {inf[0] ? sgn[0] : sgn[1], 8'hFF, 23'd0};
    end else if (sum_w == '0) begin
      sum_o = {eff_sub ? (rm_i == RM_RDN) : sgn[0], 31'd0};
    end else if (ovf) begin
      sum_o            = huge_inf ? {big_s, 8'hFF, 23'd0} : {big_s, 8'hFE, {23{1'b1}}};
      flags_o.overflow = 1'b1;
      flags_o.inexact  = 1'b1;
    end else begin
      sum_o             = {big_s, pk[30:0]};
      flags_o.inexact   = inx;
      flags_o.underflow = tiny & inx;
    end
  end
endmodule

// File: rtl/fadd_rc_sel.sv
module fadd_rc_sel (
  input  logic       er_en_i,
  input  logic       src2_reg_i,
  input  logic [1:0] er_rc_i,
  input  logic [1:0] glob_rc_i,
  output logic [1:0] rm_o
);
  // override only valid for a register second operand
  assign rm_o = (er_en_i & src2_reg_i) ? er_rc_i : glob_rc_i;
endmodule

// File: rtl/fadd_lane_merge.sv
module fadd_lane_merge
  import scalar_fadd_pkg::*;
#(
  parameter int VW = 512,
  parameter int XW = 128
) (
  input  logic [1:0]      mode_i,
  input  logic            mask_en_i,
  input  logic            mask_bit_i,
  input  logic            zero_mask_i,
  input  logic [VW-1:0]   dst_i,
  input  logic [XW-1:FP_W] src1_hi_i,
  input  logic [FP_W-1:0] sum_i,
  input  fflags_t         flags_i,
  output logic [VW-1:0]   vec_o,
  output fflags_t         flags_o
);
  localparam int ZW = VW - XW;

  logic                 lane_on, legacy;
  logic [FP_W-1:0]      lo;
  logic [VW-1:FP_W]     upper_new;

  assign legacy  = mode_i == MD_LEGACY;
  assign lane_on = (mode_i != MD_MASKED) | ~mask_en_i | mask_bit_i;

  if (ZW > 0) begin : g_pad
    assign upper_new = {{ZW{1'b0}}, src1_hi_i};
  end else begin : g_nopad
    assign upper_new = src1_hi_i;
  end

  always_comb begin
    if (lane_on)          lo = sum_i;
    else if (zero_mask_i) lo = '0;
    else                  lo = dst_i[FP_W-1:0];
  end

  assign vec_o   = {legacy ? dst_i[VW-1:FP_W] : upper_new, lo};
  assign flags_o = lane_on ? flags_i : '0;
endmodule

// File: rtl/scalar_fadd.sv
module scalar_fadd
  import scalar_fadd_pkg::*;
#(
  parameter int VW      = 512,
  parameter int XW      = 128,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      mode_i,
  input  logic [XW-1:0]   src1_i,
  input  logic [FP_W-1:0] src2_i,
  input  logic [VW-1:0]   dst_i,
  input  logic            mask_en_i,
  input  logic            mask_bit_i,
  input  logic            zero_mask_i,
  input  logic            er_en_i,
  input  logic [1:0]      er_rc_i,
  input  logic            src2_reg_i,
  input  logic [1:0]      glob_rc_i,
  output logic [VW-1:0]   res_o,
  output logic [4:0]      flags_o
);
  logic [1:0]      rm;
  logic [FP_W-1:0] opa, sum;
  fflags_t         core_fl, merged_fl;
  logic [VW-1:0]   res_d;

  // legacy form: first source is the destination itself
  assign opa = (mode_i == MD_LEGACY) ? dst_i[FP_W-1:0] : src1_i[FP_W-1:0];

  fadd_rc_sel u_rc (
    .er_en_i    (er_en_i),
    .src2_reg_i (src2_reg_i),
    .er_rc_i    (er_rc_i),
    .glob_rc_i  (glob_rc_i),
    .rm_o       (rm)
  );

  fp32_add_core u_add (
    .a_i     (opa),
    .b_i     (src2_i),
    .rm_i    (rm),
    .sum_o   (sum),
    .flags_o (core_fl)
  );

  fadd_lane_merge #(.VW(VW), .XW(XW)) u_merge (
    .mode_i      (mode_i),
    .mask_en_i   (mask_en_i),
    .mask_bit_i  (mask_bit_i),
    .zero_mask_i (zero_mask_i),
    .dst_i       (dst_i),
    .src1_hi_i   (src1_i[XW-1:FP_W]),
    .sum_i       (sum),
    .flags_i     (core_fl),
    .vec_o       (res_d),
    .flags_o     (merged_fl)
  );

  if (REG_OUT) begin : g_oreg
    logic [VW-1:0] res_q;
    logic [4:0]    flg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_q <= '0;
        flg_q <= '0;
      end else begin
        res_q <= res_d;
        flg_q <= merged_fl;
      end
    end
    assign res_o   = res_q;
    assign flags_o = flg_q;
  end else begin : g_comb
    assign res_o   = res_d;
    assign flags_o = merged_fl;
  end
endmodule

// File: rtl/scalar_fadd_chk.sv
module scalar_fadd_chk
  import scalar_fadd_pkg::*;
#(
  parameter int VW      = 512,
  parameter int XW      = 128,
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      mode_i,
  input logic [XW-1:0]   src1_i,
  input logic [VW-1:0]   dst_i,
  input logic            mask_en_i,
  input logic            mask_bit_i,
  input logic            zero_mask_i,
  input logic [VW-1:0]   res_o,
  input logic [4:0]      flags_o
);
  // inputs aligned with the cycle the outputs reflect
  logic [1:0]        d_mode;
  logic              d_off, d_zm, seen;
  logic [XW-1:FP_W]  d_src1;
  logic [VW-1:0]     d_dst;
  logic              off_now;

  assign off_now = (mode_i == MD_MASKED) & mask_en_i & ~mask_bit_i;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_mode <= '0; d_off <= 1'b0; d_zm <= 1'b0;
        d_src1 <= '0; d_dst <= '0;   seen <= 1'b0;
      end else begin
        d_mode <= mode_i; d_off <= off_now; d_zm <= zero_mask_i;
        d_src1 <= src1_i[XW-1:FP_W]; d_dst <= dst_i; seen <= 1'b1;
      end
    end
  end else begin : g_now
    assign d_mode = mode_i;
    assign d_off  = off_now;
    assign d_zm   = zero_mask_i;
    assign d_src1 = src1_i[XW-1:FP_W];
    assign d_dst  = dst_i;
    assign seen   = 1'b1;
  end

  p_merge_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && d_off && !d_zm) |-> (res_o[FP_W-1:0] == d_dst[FP_W-1:0]));

  p_zero_lane_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && d_off && d_zm) |-> (res_o[FP_W-1:0] == '0));

  p_upper_copy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && d_mode != MD_LEGACY) |-> (res_o[XW-1:FP_W] == d_src1));

  if (VW > XW) begin : g_top_zero
    p_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen && d_mode != MD_LEGACY) |-> (res_o[VW-1:XW] == '0));
  end

  p_legacy_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && d_mode == MD_LEGACY) |-> (res_o[VW-1:FP_W] == d_dst[VW-1:FP_W]));

  p_ovf_inexact_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[2] |-> flags_o[4]);

  p_invalid_qnan_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[0] |-> (res_o[FP_W-1:0] == QNAN_DFLT));

  p_unf_inexact_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[3] |-> flags_o[4]);

  p_no_flags_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && d_off) |-> (flags_o == '0));
endmodule

bind scalar_fadd scalar_fadd_chk #(.VW(VW), .XW(XW), .REG_OUT(REG_OUT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .src1_i      (src1_i),
  .dst_i       (dst_i),
  .mask_en_i   (mask_en_i),
  .mask_bit_i  (mask_bit_i),
  .zero_mask_i (zero_mask_i),
  .res_o       (res_o),
  .flags_o     (flags_o)
);

// File: tb/scalar_fadd_test.sv
module scalar_fadd_test;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 512;
  localparam int XW = 128;

  localparam logic [1:0] LEG = 2'b00, TRI = 2'b01, MSK = 2'b10, TRB = 2'b11;
  localparam logic [1:0] RNE = 2'b00, RDN = 2'b01, RUP = 2'b10, RTZ = 2'b11;
  localparam logic [95:0] S1_HI  = 96'h1357_9BDF_2468_ACE0_F00D_BEEF;
  localparam logic [31:0] DLO    = 32'hD0D0_0000;
  localparam logic [31:0] ONE    = 32'h3F80_0000;
  localparam logic [31:0] TWO    = 32'h4000_0000;
  localparam logic [31:0] SNAN   = 32'h7F80_0001;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode = 2'b00;
  logic [XW-1:0]   src1 = '0;
  logic [31:0]     src2 = '0;
  logic [VW-1:0]   dst = '0;
  logic            men = 1'b0, mbit = 1'b0, zm = 1'b0;
  logic            ere = 1'b0, sreg = 1'b0;
  logic [1:0]      erc = 2'b00, grc = 2'b00;
  logic [VW-1:0]   res;
  logic [4:0]      flg;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scalar_fadd uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .src1_i(src1), .src2_i(src2),
    .dst_i(dst), .mask_en_i(men), .mask_bit_i(mbit), .zero_mask_i(zm),
    .er_en_i(ere), .er_rc_i(erc), .src2_reg_i(sreg), .glob_rc_i(grc),
    .res_o(res), .flags_o(flg)
  );

  function automatic logic [VW-1:0] dst_pat(input logic [31:0] lo);
    logic [VW-1:0] v;
    for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = 32'hD0D0_0000 | 32'(i);
    v[31:0] = lo;
    return v;
  endfunction

  task automatic chk(input string rq, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] md, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] dlo, input logic me, input logic mb, input logic z,
                       input logic e, input logic [1:0] ec, input logic sr, input logic [1:0] gc);
    @(negedge clk);
    mode = md; src1 = {S1_HI, a}; src2 = b; dst = dst_pat(dlo);
    men = me; mbit = mb; zm = z; ere = e; erc = ec; sreg = sr; grc = gc;
    @(posedge clk);
    #1;
  endtask

  task automatic add(input logic [1:0] md, input logic [31:0] a, input logic [31:0] b,
                     input logic [1:0] gc);
    apply(md, a, b, DLO, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, gc);
  endtask

  task automatic t_reset;
    #1;
    chk("R13 reset res", res, '0);
    chk("R13 reset flags", {507'd0, flg}, '0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_masked_sum;
    apply(MSK, ONE, TWO, DLO, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1, RNE);
    chk("R1 masked k=1 lane", res[31:0], 32'h4040_0000);
    chk("R4 upper copy", res[127:32], S1_HI);
    chk("R4 upper zero", res[511:128], '0);
    chk("R1 flags", flg, 5'b00000);
    apply(MSK, ONE, TWO, DLO, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, RNE);
    chk("R1 no mask in use", res[31:0], 32'h4040_0000);
  endtask

  task automatic t_trio;
    apply(TRI, ONE, TWO, DLO, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, RNE);
    chk("R1 three-op ignores mask", res[31:0], 32'h4040_0000);
    chk("R4 three-op upper copy", res[127:32], S1_HI);
    chk("R4 three-op upper zero", res[511:128], '0);
    apply(TRB, ONE, TWO, DLO, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, RNE);
    chk("R1 mode 11 lane", res[31:0], 32'h4040_0000);
    chk("R4 mode 11 upper zero", res[511:128], '0);
  endtask

  task automatic t_legacy;
    apply(LEG, TWO, ONE, ONE, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, RNE);
    chk("R5 legacy lane", res[31:0], 32'h4000_0000);
    chk("R5 legacy upper", res[511:32], dst_pat(ONE) >> 32);
  endtask

  task automatic t_masked_off;
    apply(MSK, SNAN, ONE, DLO, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, RNE);
    chk("R2 merge keeps dst", res[31:0], DLO);
    chk("R12 merge flags", flg, 5'b00000);
    chk("R4 merge upper", res[127:32], S1_HI);
    apply(MSK, SNAN, ONE, DLO, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, RNE);
    chk("R3 zero lane", res[31:0], 32'h0);
    chk("R12 zero flags", flg, 5'b00000);
  endtask

  task automatic t_round_sel;
    apply(TRI, ONE, 32'h3380_0000, DLO, 1'b0, 1'b0, 1'b0, 1'b1, RUP, 1'b1, RNE);
    chk("R6 override used", res[31:0], 32'h3F80_0001);
    apply(TRI, ONE, 32'h3380_0000, DLO, 1'b0, 1'b0, 1'b0, 1'b1, RUP, 1'b0, RNE);
    chk("R6 memory operand uses global", res[31:0], 32'h3F80_0000);
    apply(TRI, ONE, 32'h3380_0000, DLO, 1'b0, 1'b0, 1'b0, 1'b0, RNE, 1'b1, RUP);
    chk("R6 disabled uses global", res[31:0], 32'h3F80_0001);
  endtask

  task automatic t_round_modes;
    add(TRI, ONE, 32'h3380_0000, RNE);
    chk("R7 tie to even down", res[31:0], 32'h3F80_0000);
    chk("R7 inexact flag", flg, 5'b10000);
    add(TRI, 32'h3F80_0001, 32'h3380_0000, RNE);
    chk("R7 tie to even up", res[31:0], 32'h3F80_0002);
    add(TRI, ONE, 32'h3380_0000, RTZ);
    chk("R7 toward zero", res[31:0], 32'h3F80_0000);
    add(TRI, 32'hBF80_0000, 32'hB380_0000, RDN);
    chk("R7 neg toward minus", res[31:0], 32'hBF80_0001);
    add(TRI, 32'hBF80_0000, 32'hB380_0000, RUP);
    chk("R7 neg toward plus", res[31:0], 32'hBF80_0000);
    add(TRI, ONE, 32'h0D80_0000, RUP);
    chk("R7 sticky only up", res[31:0], 32'h3F80_0001);
    add(TRI, ONE, 32'hBF40_0000, RNE);
    chk("R7 cancel normalise", res[31:0], 32'h3E80_0000);
    chk("R7 exact flags", flg, 5'b00000);
  endtask

  task automatic t_overflow;
    add(TRI, 32'h7F7F_FFFF, 32'h7F7F_FFFF, RNE);
    chk("R8 nearest to inf", res[31:0], 32'h7F80_0000);
    chk("R8 flags", flg, 5'b10100);
    add(TRI, 32'h7F7F_FFFF, 32'h7F7F_FFFF, RTZ);
    chk("R8 toward zero max", res[31:0], 32'h7F7F_FFFF);
    add(TRI, 32'hFF7F_FFFF, 32'hFF7F_FFFF, RUP);
    chk("R8 neg toward plus max", res[31:0], 32'hFF7F_FFFF);
  endtask

  task automatic t_invalid;
    add(TRI, 32'h7F80_0000, 32'hFF80_0000, RNE);
    chk("R9 inf minus inf", res[31:0], 32'h7FC0_0000);
    chk("R9 invalid flag", flg, 5'b00001);
    add(TRI, SNAN, ONE, RNE);
    chk("R9 snan", res[31:0], 32'h7FC0_0000);
    chk("R9 snan flag", flg, 5'b00001);
    add(TRI, ONE, 32'h7FC1_2345, RNE);
    chk("R9 qnan propagate", res[31:0], 32'h7FC1_2345);
    chk("R9 qnan no flag", flg, 5'b00000);
    add(TRI, 32'h7F80_0000, ONE, RNE);
    chk("R9 inf plus finite", res[31:0], 32'h7F80_0000);
  endtask

  task automatic t_denorm;
    add(TRI, 32'h0000_0001, 32'h0000_0001, RNE);
    chk("R10 subnormal sum", res[31:0], 32'h0000_0002);
    chk("R10 denormal flag only", flg, 5'b00010);
    add(TRI, 32'h0040_0000, 32'h0040_0000, RNE);
    chk("R10 subnormal to normal", res[31:0], 32'h0080_0000);
  endtask

  task automatic t_zero_sign;
    add(TRI, ONE, 32'hBF80_0000, RNE);
    chk("R11 plus zero", res[31:0], 32'h0000_0000);
    add(TRI, ONE, 32'hBF80_0000, RDN);
    chk("R11 minus zero", res[31:0], 32'h8000_0000);
    add(TRI, 32'h8000_0000, 32'h8000_0000, RNE);
    chk("R11 neg zeros", res[31:0], 32'h8000_0000);
  endtask

  task automatic t_latency;
    add(TRI, ONE, TWO, RNE);
    @(negedge clk);
    src2 = ONE;
    #1;
    chk("R13 holds before edge", res[31:0], 32'h4040_0000);
    @(posedge clk);
    #1;
    chk("R13 updates after edge", res[31:0], 32'h4000_0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset;
    t_masked_sum;
    t_trio;
    t_legacy;
    t_masked_off;
    t_round_sel;
    t_round_modes;
    t_overflow;
    t_invalid;
    t_denorm;
    t_zero_sign;
    t_latency;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule